// File: doc/BRIEF.md
# UART Transmitter with Break and Idle Sequencing

This block serialises bytes onto an asynchronous line and adds the line conditions that software needs around ordinary data: an all-ones idle character each time the transmitter is switched on, break characters (an all-zero character, stop slot included) on request, and a queued idle character when the transmitter is switched off and on again while a character is still on the wire. An external baud tick runs at sixteen times the bit rate, and every bit lasts sixteen ticks.

Software controls the block through a control write, which carries a transmitter-enable value and a break value, and through a data write, which loads one byte into a holding register. A module-enable input gates writes to the transmitter-enable bit. The transmit-empty flag shows when the holding register can take the next byte. Whenever no character is active, the serial output rests at logic 1.

Top module: `ser_tx_brk`

## Requirements
- R1: A data character is ten bit times long: a 0 start bit, then the eight bits of the byte with bit 0 first, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R2: When the transmitter enable goes from 0 to 1 while no character is active, the block sends a preamble of ten logic-1 bit times before any data.
- R3: tx_empty is 1 after reset. A data write clears it to 0. It returns to 1 in the cycle after the byte moves from the holding register into the shifter. If a data write happens in that same cycle, the write wins and tx_empty stays 0.
- R4: While mod_en is 0, a control write leaves the transmitter enable unchanged. The break value is still written.
- R5: If the transmitter enable is cleared and then set again while a character is active, one idle character of ten logic-1 bit times follows the active character, and no preamble is sent.
- R6: Setting the break bit and then clearing it sends one break character of ten zero bit times. One logic-1 bit time follows it before any later character.
- R7: While the break bit stays 1, break characters follow each other with no logic-1 bit between them.
- R8: If the break bit is set after an enable edge but before the preamble has started, a break character is sent and the preamble is dropped.
- R9: Reset clears the transmitter enable and the break bit, and txd is 1 after reset. With the enable clear, no new character starts, and txd is 1 whenever no character is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mod_en | input | 1 | Module enable; gates writes to the transmitter enable |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| ctl_wr | input | 1 | Control write strobe |
| ctl_tx_en | input | 1 | Transmitter-enable value carried by a control write |
| ctl_brk | input | 1 | Break value carried by a control write |
| data_wr | input | 1 | Data write strobe |
| data_in | input | DATA_W | Byte to transmit |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Holding register free |

## Verification
The data path is driven with bytes whose bit patterns differ, 0xA5, 0x3C, 0x81 and 0x55, so that a swapped bit order or a shifted stop bit changes the line. The enable bit is toggled in three ways. With the line idle, the toggle must produce a preamble. During an active character, it must produce a queued idle. With mod_en low, it must have no effect at all. The break bit is pulsed briefly, held across several characters, and set in the gap before a preamble. These three cases separate single breaks, back-to-back breaks and break replacement from one another. The baud tick can be paused, which places the control writes at known character boundaries.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_PRE  = 3'd1,
    K_IDLE = 3'd2,
    K_BRK  = 3'd3,
    K_MARK = 3'd4,
    K_DATA = 3'd5
  } kind_e;

  // number of bit times a character of the given kind occupies
  function automatic int unsigned char_bits(kind_e k, int unsigned frame_bits);
    return (k == K_MARK) ? 1 : frame_bits;
  endfunction

endpackage

// File: rtl/stx_regs.sv
module stx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              ctl_wr,
  input  logic              ctl_tx_en,
  input  logic              ctl_brk,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              eng_busy,
  input  logic              ld_data,
  input  logic              ld_brk,
  output logic              tx_en,
  output logic              brk_on,
  output logic              brk_lat,
  output logic [DATA_W-1:0] hold,
  output logic              tx_empty,
  output logic              en_rise_busy,
  output logic              en_rise_idle
);

  logic en_wr_ok;
  logic en_rise;
  logic brk_rise;

  assign en_wr_ok     = ctl_wr && mod_en;
  assign en_rise      = en_wr_ok && ctl_tx_en && !tx_en;
  assign en_rise_busy = en_rise && eng_busy;
  assign en_rise_idle = en_rise && !eng_busy;
  assign brk_rise     = ctl_wr && ctl_brk && !brk_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      brk_on   <= 1'b0;
      brk_lat  <= 1'b0;
      hold     <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (en_wr_ok) tx_en <= ctl_tx_en;
      if (ctl_wr)   brk_on <= ctl_brk;
      if (brk_rise)    brk_lat <= 1'b1;
      else if (ld_brk) brk_lat <= 1'b0;
      if (data_wr) begin
        hold     <= data_in;
        tx_empty <= 1'b0;
      end else if (ld_data) begin
        tx_empty <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/stx_sched.sv
module stx_sched
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FB = DATA_W + 2,
  localparam int BW = $clog2(FB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              brk_on,
  input  logic              brk_lat,
  input  logic [DATA_W-1:0] hold,
  input  logic              tx_empty,
  input  logic              en_rise_busy,
  input  logic              en_rise_idle,
  input  logic              slot_free,
  output logic              ld,
  output kind_e             ld_kind,
  output logic [FB-1:0]     ld_frame,
  output logic [BW-1:0]     ld_bits,
  output logic              ld_data,
  output logic              ld_brk
);

  logic pre_p;
  logic idl_p;
  logic grd_p;

  function automatic logic [FB-1:0] build_frame(kind_e k, logic [DATA_W-1:0] d);
    case (k)
      K_BRK:   return '0;
      K_DATA:  return {1'b1, d, 1'b0};
      default: return '1;
    endcase
  endfunction

  always_comb begin
    if (!tx_en)                ld_kind = K_NONE;
    else if (brk_on || brk_lat) ld_kind = K_BRK;
    else if (grd_p)            ld_kind = K_MARK;
    else if (idl_p)            ld_kind = K_IDLE;
    else if (pre_p)            ld_kind = K_PRE;
    else if (!tx_empty)        ld_kind = K_DATA;
    else                       ld_kind = K_NONE;
  end

  assign ld       = slot_free && (ld_kind != K_NONE);
  assign ld_data  = ld && (ld_kind == K_DATA);
  assign ld_brk   = ld && (ld_kind == K_BRK);
  assign ld_frame = build_frame(ld_kind, hold);
  assign ld_bits  = BW'(char_bits(ld_kind, FB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_p <= 1'b0;
      idl_p <= 1'b0;
      grd_p <= 1'b0;
    end else begin
      if (en_rise_idle) pre_p <= 1'b0 | 1'b1;
      else if (ld && (ld_kind == K_PRE || ld_kind == K_BRK)) pre_p <= 1'b0;
      if (en_rise_busy) idl_p <= 1'b1;
      else if (ld && ld_kind == K_IDLE) idl_p <= 1'b0;
      if (ld_brk) grd_p <= 1'b1;
      else if (ld && ld_kind == K_MARK) grd_p <= 1'b0;
    end
  end

endmodule

// File: rtl/stx_shift.sv
module stx_shift #(
  parameter int FB  = 10,
  parameter int OVS = 16,
  localparam int BW    = $clog2(FB + 1),
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          ld,
  input  logic [FB-1:0] ld_frame,
  input  logic [BW-1:0] ld_bits,
  output logic          txd,
  output logic          busy,
  output logic          slot_free,
  output logic          char_end
);

  logic [FB-1:0]    sh;
  logic [BW-1:0]    nbits;
  logic [BW-1:0]    bit_cnt;
  logic [SUB_W-1:0] sub;
  logic             bit_end;

  assign bit_end   = baud_tick && busy && (sub == SUB_W'(OVS - 1));
  assign char_end  = bit_end && (bit_cnt == nbits - BW'(1));
  assign slot_free = baud_tick && (!busy || char_end);
  assign txd       = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '1;
      nbits   <= '0;
      bit_cnt <= '0;
      sub     <= '0;
      busy    <= 1'b0;
    end else if (ld) begin
      sh      <= ld_frame;
      nbits   <= ld_bits;
      bit_cnt <= '0;
      sub     <= '0;
      busy    <= 1'b1;
    end else if (char_end) begin
      sh   <= '1;
      sub  <= '0;
      busy <= 1'b0;
    end else if (bit_end) begin
      sub     <= '0;
      bit_cnt <= bit_cnt + BW'(1);
      sh      <= {1'b1, sh[FB-1:1]};
    end else if (baud_tick && busy) begin
      sub <= sub + SUB_W'(1);
    end
  end

endmodule

// File: rtl/ser_tx_brk.sv
module ser_tx_brk
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              baud_tick,
  input  logic              ctl_wr,
  input  logic              ctl_tx_en,
  input  logic              ctl_brk,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  output logic              txd,
  output logic              tx_empty
);

  localparam int FB = DATA_W + 2;
  localparam int BW = $clog2(FB + 1);

  logic              tx_en;
  logic              brk_on;
  logic              brk_lat;
  logic [DATA_W-1:0] hold;
  logic              en_rise_busy;
  logic              en_rise_idle;
  logic              busy;
  logic              slot_free;
  logic              char_end;
  logic              ld;
  kind_e             ld_kind;
  logic [FB-1:0]     ld_frame;
  logic [BW-1:0]     ld_bits;
  logic              ld_data;
  logic              ld_brk;

  stx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_en       (mod_en),
    .ctl_wr       (ctl_wr),
    .ctl_tx_en    (ctl_tx_en),
    .ctl_brk      (ctl_brk),
    .data_wr      (data_wr),
    .data_in      (data_in),
    .eng_busy     (busy),
    .ld_data      (ld_data),
    .ld_brk       (ld_brk),
    .tx_en        (tx_en),
    .brk_on       (brk_on),
    .brk_lat      (brk_lat),
    .hold         (hold),
    .tx_empty     (tx_empty),
    .en_rise_busy (en_rise_busy),
    .en_rise_idle (en_rise_idle)
  );

  stx_sched #(.DATA_W(DATA_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .brk_on       (brk_on),
    .brk_lat      (brk_lat),
    .hold         (hold),
    .tx_empty     (tx_empty),
    .en_rise_busy (en_rise_busy),
    .en_rise_idle (en_rise_idle),
    .slot_free    (slot_free),
    .ld           (ld),
    .ld_kind      (ld_kind),
    .ld_frame     (ld_frame),
    .ld_bits      (ld_bits),
    .ld_data      (ld_data),
    .ld_brk       (ld_brk)
  );

  stx_shift #(.FB(FB), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .ld        (ld),
    .ld_frame  (ld_frame),
    .ld_bits   (ld_bits),
    .txd       (txd),
    .busy      (busy),
    .slot_free (slot_free),
    .char_end  (char_end)
  );

endmodule

// File: rtl/stx_chk.sv
module stx_chk
  import stx_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  mod_en,
  input logic  ctl_wr,
  input logic  data_wr,
  input logic  tx_en,
  input logic  brk_on,
  input logic  busy,
  input logic  txd,
  input logic  tx_empty,
  input logic  ld,
  input kind_e ld_kind
);

  // R4
  en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !mod_en) |=> $stable(tx_en));

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R3
  empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_empty);

  // R3
  empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_kind == K_DATA && !data_wr) |=> tx_empty);

  // R7
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && brk_on) |-> (ld_kind == K_BRK));

  // R9
  ld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> tx_en);

  // R1
  busy_after_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> busy);

endmodule

bind ser_tx_brk stx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mod_en   (mod_en),
  .ctl_wr   (ctl_wr),
  .data_wr  (data_wr),
  .tx_en    (tx_en),
  .brk_on   (brk_on),
  .busy     (busy),
  .txd      (txd),
  .tx_empty (tx_empty),
  .ld       (ld),
  .ld_kind  (ld_kind)
);

// File: tb/ser_tx_brk_tb.sv
module ser_tx_brk_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       ctl_wr = 1'b0;
  logic       ctl_tx_en = 1'b0;
  logic       ctl_brk = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       txd;
  logic       tx_empty;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    tick_en = 1'b0;
  int    tick_div = 0;
  string cur_req = "R9";

  // reference model state
  int m_q[$];
  int m_sub = 0;
  bit m_ten = 0, m_brk = 0, m_blat = 0, m_empty = 1;
  bit m_pre = 0, m_idl = 0, m_grd = 0;
  logic [7:0] m_hold = 8'h00;

  always #10 clk = ~clk;

  ser_tx_brk u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .baud_tick (baud_tick),
    .ctl_wr    (ctl_wr),
    .ctl_tx_en (ctl_tx_en),
    .ctl_brk   (ctl_brk),
    .data_wr   (data_wr),
    .data_in   (data_in),
    .txd       (txd),
    .tx_empty  (tx_empty)
  );

  // baud tick: one cycle in four while enabled
  always @(negedge clk) begin
    if (tick_en) begin
      tick_div  = (tick_div + 1) % 4;
      baud_tick = (tick_div == 0);
    end else begin
      baud_tick = 1'b0;
    end
  end

  // behavioural line model: a queue of bit values, each held for 16 ticks
  always @(posedge clk) begin
    bit was_busy, free, ten_o, brk_o, blat_o, empty_o;
    logic [7:0] hold_o;
    if (!rst_n) begin
      m_q.delete(); m_sub = 0;
      m_ten = 0; m_brk = 0; m_blat = 0; m_empty = 1;
      m_pre = 0; m_idl = 0; m_grd = 0; m_hold = 8'h00;
    end else begin
      was_busy = (m_q.size() != 0);
      ten_o = m_ten; brk_o = m_brk; blat_o = m_blat;
      empty_o = m_empty; hold_o = m_hold;
      free = 0;
      if (baud_tick) begin
        if (!was_busy) free = 1;
        else begin
          m_sub++;
          if (m_sub == 16) begin
            m_sub = 0;
            void'(m_q.pop_front());
            if (m_q.size() == 0) free = 1;
          end
        end
      end
      if (free && ten_o) begin
        m_sub = 0;
        if (brk_o || blat_o) begin
          repeat (10) m_q.push_back(0);
          m_pre = 0; m_blat = 0; m_grd = 1;
        end else if (m_grd) begin
          m_q.push_back(1); m_grd = 0;
        end else if (m_idl) begin
          repeat (10) m_q.push_back(1); m_idl = 0;
        end else if (m_pre) begin
          repeat (10) m_q.push_back(1); m_pre = 0;
        end else if (!empty_o) begin
          m_q.push_back(0);
          for (int i = 0; i < 8; i++) m_q.push_back(int'(hold_o[i]));
          m_q.push_back(1);
          m_empty = 1;
        end
      end
      if (ctl_wr) begin
        if (mod_en) begin
          if (ctl_tx_en && !ten_o) begin
            if (was_busy) m_idl = 1; else m_pre = 1;
          end
          m_ten = ctl_tx_en;
        end
        if (ctl_brk && !brk_o) m_blat = 1;
        m_brk = ctl_brk;
      end
      if (data_wr) begin
        m_hold = data_in; m_empty = 0;
      end
    end
  end

  function automatic bit model_txd();
    return (m_q.size() != 0) ? m_q[0][0] : 1'b1;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (txd !== model_txd() || tx_empty !== m_empty) begin
        n_fail++;
        $display("FAIL %s model: txd=%b tx_empty=%b expected txd=%b tx_empty=%b at %0t",
                 cur_req, txd, tx_empty, model_txd(), m_empty, $time);
      end
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(bit en, bit brk);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_tx_en = en; ctl_brk = brk;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic put(logic [7:0] d);
    @(negedge clk);
    data_wr = 1'b1; data_in = d;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clks(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", txd, 1'b1, "txd after reset");
    check("R3", tx_empty, 1'b1, "tx_empty after reset");
    tick_en = 1'b1;
    mod_en  = 1'b1;

    // R2 preamble then R1 data frame
    cur_req = "R2";
    ctl(1'b1, 1'b0);
    clks(200);
    check("R2", txd, 1'b1, "line high during preamble");
    cur_req = "R1";
    put(8'hA5);
    check("R3", tx_empty, 1'b0, "tx_empty after data write");
    clks(1400);
    check("R3", tx_empty, 1'b1, "tx_empty after byte taken");
    put(8'h3C);
    clks(40);
    put(8'hC3);
    clks(1400);

    // R4: enable writes ignored while module disabled
    cur_req = "R4";
    ctl(1'b0, 1'b0);
    clks(700);
    mod_en = 1'b0;
    ctl(1'b1, 1'b0);
    put(8'h55);
    clks(1500);
    check("R4", tx_empty, 1'b0, "byte held while enable write ignored");
    check("R4", txd, 1'b1, "line idle while enable write ignored");
    mod_en = 1'b1;

    // R5: enable cleared and set during the preamble
    cur_req = "R5";
    ctl(1'b1, 1'b0);
    clks(100);
    ctl(1'b0, 1'b0);
    clks(20);
    ctl(1'b1, 1'b0);
    clks(3000);
    check("R5", tx_empty, 1'b1, "byte sent after queued idle");

    // R6: single break then guard mark
    cur_req = "R6";
    ctl(1'b1, 1'b1);
    clks(6);
    ctl(1'b1, 1'b0);
    clks(300);
    check("R6", txd, 1'b0, "line low during break");
    clks(1200);
    put(8'h81);
    clks(1500);

    // R7: break held across several characters
    cur_req = "R7";
    ctl(1'b1, 1'b1);
    clks(1800);
    check("R7", txd, 1'b0, "line low between back-to-back breaks");
    ctl(1'b1, 1'b0);
    clks(1500);

    // R8: break set before the preamble has started
    cur_req = "R8";
    ctl(1'b0, 1'b0);
    clks(800);
    tick_en = 1'b0;
    ctl(1'b1, 1'b0);
    ctl(1'b1, 1'b1);
    ctl(1'b1, 1'b0);
    tick_en = 1'b1;
    clks(200);
    check("R8", txd, 1'b0, "break sent in place of preamble");
    clks(1500);
    check("R8", txd, 1'b1, "line idle after replacement break");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule